// File: doc/BRIEF.md
# Doorbell Message Router

This block carries doorbell messages between the cores of a cluster. A core that sends a message presents one 32-bit message word on the send port. The word holds a message type, a broadcast flag and a target tag. The router compares the tag with the processor ID held for each core. On every core the message reaches, it sets a normal or a critical doorbell pending bit. In the next cycle it gives each of those cores a one-cycle interrupt-request pulse.

A separate clear port names the issuing core and carries a message word. Only the type field of that word is used, and it selects which of that core's pending bits to drop. Guest-class message types are accepted and then dropped without any effect. Each core's processor ID can be rewritten through a small write port. Arbitration between interrupt sources inside a core is left to the core.

Top module: `doorbell_router`

## Requirements
- R1: After reset every pending bit and every interrupt pulse is 0, and core i holds processor ID i.
- R2: A send whose type field (word bits [31:27]) is 0 sets the normal pending bit on each targeted core. Type 1 sets the critical pending bit instead.
- R3: A send of type 2, 3 or 4 (guest normal, guest critical and guest machine-check), or of any type from 5 to 31, changes no pending bit and raises no interrupt pulse.
- R4: A core is targeted when the tag (word bits [13:0]) equals its processor ID, or on every core when the broadcast bit (word bit 26) is 1. A tag that matches no ID and has the broadcast bit at 0 targets nothing.
- R5: A targeted core's interrupt pulse is high for exactly the one cycle after the send is sampled. Cores that were not targeted see no pulse.
- R6: A clear acts only on the core named by its core index, and only on the pending bit that its type field maps to. Types 2 to 31 on the clear port have no effect.
- R7: When a send and a clear reach the same core with the same type in the same cycle, the pending bit ends up set.
- R8: A write on the ID port replaces the processor ID of the selected core. Sends sampled after the write match against the new value.
- R9: Pending bits hold their value while neither port is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | 1 | Send command valid |
| snd_word | input | 32 | Send message word (type, broadcast, tag) |
| clr_valid | input | 1 | Clear command valid |
| clr_core | input | IDX_W | Index of the issuing core for a clear |
| clr_word | input | 32 | Clear message word (only the type is used) |
| id_we | input | 1 | Processor ID write enable |
| id_core | input | IDX_W | Core whose processor ID is written |
| id_val | input | 14 | New processor ID value |
| pend_norm | output | NUM_CORES | Normal doorbell pending bit, one per core |
| pend_crit | output | NUM_CORES | Critical doorbell pending bit, one per core |
| irq_pulse | output | NUM_CORES | One-cycle interrupt request, one per core |

## Verification
The assertions take the index on `clr_core` and `id_core` to be below NUM_CORES whenever its valid or write enable is high. They also take the command inputs to settle before each sampling edge. The bench drives every input on the falling edge and uses only indices of existing cores, so both conditions hold. Commands are spaced with idle cycles, so every interrupt pulse can be seen both rising and falling.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
   // Decoded meaning of a message type field.
   typedef enum logic [1:0] {
      DB_NONE = 2'd0,
      DB_NORM = 2'd1,
      DB_CRIT = 2'd2
   } db_kind_e;

   localparam int unsigned DB_CODE_NORM = 0;
   localparam int unsigned DB_CODE_CRIT = 1;
endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
   import doorbell_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int TYPE_LSB  = 27,
   parameter int TYPE_W    = 5,
   parameter int BCAST_BIT = 26,
   parameter int ID_W      = 14
) (
   input  logic [WORD_W-1:0] word_i,
   output db_kind_e          kind_o,
   output logic              bcast_o,
   output logic [ID_W-1:0]   tag_o
);
   logic [TYPE_W-1:0] type_f;
   logic              unused_mid;

   assign type_f     = word_i[TYPE_LSB +: TYPE_W];
   assign bcast_o    = word_i[BCAST_BIT];
   assign tag_o      = word_i[ID_W-1:0];
   assign unused_mid = ^word_i[BCAST_BIT-1:ID_W];

   // Guest classes and undefined codes fall through to DB_NONE.
   always_comb begin
      if (type_f == TYPE_W'(DB_CODE_NORM))      kind_o = DB_NORM;
      else if (type_f == TYPE_W'(DB_CODE_CRIT)) kind_o = DB_CRIT;
      else                                      kind_o = DB_NONE;
   end
endmodule

// File: rtl/doorbell_slot.sv
module doorbell_slot
   import doorbell_pkg::*;
#(
   parameter int ID_W   = 14,
   parameter int ID_RST = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            snd_valid,
   input  db_kind_e        snd_kind,
   input  logic            snd_bcast,
   input  logic [ID_W-1:0] snd_tag,
   input  logic            clr_sel,
   input  db_kind_e        clr_kind,
   input  logic            id_sel,
   input  logic [ID_W-1:0] id_val,
   output logic            pend_norm_o,
   output logic            pend_crit_o,
   output logic            irq_o
);
   logic [ID_W-1:0] id_q;
   logic            hit;
   logic            set_n, set_c, clr_n, clr_c;

   assign hit   = snd_valid && (snd_kind != DB_NONE) && (snd_bcast || snd_tag == id_q);
   assign set_n = hit && snd_kind == DB_NORM;
   assign set_c = hit && snd_kind == DB_CRIT;
   assign clr_n = clr_sel && clr_kind == DB_NORM;
   assign clr_c = clr_sel && clr_kind == DB_CRIT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q        <= ID_W'(ID_RST);
         pend_norm_o <= 1'b0;
         pend_crit_o <= 1'b0;
         irq_o       <= 1'b0;
      end else begin
         if (id_sel) id_q <= id_val;
         // set has priority over a clear in the same cycle
         if (set_n)      pend_norm_o <= 1'b1;
         else if (clr_n) pend_norm_o <= 1'b0;
         if (set_c)      pend_crit_o <= 1'b1;
         else if (clr_c) pend_crit_o <= 1'b0;
         irq_o <= hit;
      end
   end

   // R2
   norm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_norm_o) |-> $past(snd_valid && snd_kind == DB_NORM));
   // R6
   norm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_norm_o) |-> $past(clr_sel && clr_kind == DB_NORM));
   // R6
   crit_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_crit_o) |-> $past(clr_sel && clr_kind == DB_CRIT));
   // R5
   irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pend_norm_o || pend_crit_o));
   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_n && clr_n) |=> pend_norm_o);
endmodule

// File: rtl/doorbell_router.sv
module doorbell_router
   import doorbell_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int WORD_W    = 32,
   parameter int TYPE_LSB  = 27,
   parameter int TYPE_W    = 5,
   parameter int BCAST_BIT = 26,
   parameter int ID_W      = 14,
   parameter int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 snd_valid,
   input  logic [WORD_W-1:0]    snd_word,
   input  logic                 clr_valid,
   input  logic [IDX_W-1:0]     clr_core,
   input  logic [WORD_W-1:0]    clr_word,
   input  logic                 id_we,
   input  logic [IDX_W-1:0]     id_core,
   input  logic [ID_W-1:0]      id_val,
   output logic [NUM_CORES-1:0] pend_norm,
   output logic [NUM_CORES-1:0] pend_crit,
   output logic [NUM_CORES-1:0] irq_pulse
);
   generate
      if (TYPE_LSB + TYPE_W > WORD_W) begin : g_bad_type
         $error("type field exceeds message word");
      end
      if (BCAST_BIT >= TYPE_LSB || BCAST_BIT < ID_W) begin : g_bad_bcast
         $error("broadcast bit must sit between tag and type");
      end
      if (NUM_CORES < 1) begin : g_bad_cores
         $error("NUM_CORES must be at least 1");
      end
   endgenerate

   db_kind_e        snd_kind, clr_kind;
   logic            snd_bcast;
   logic [ID_W-1:0] snd_tag;
   logic            unused_clr_bcast;
   logic [ID_W-1:0] unused_clr_tag;

   doorbell_decode #(.WORD_W(WORD_W), .TYPE_LSB(TYPE_LSB), .TYPE_W(TYPE_W),
                     .BCAST_BIT(BCAST_BIT), .ID_W(ID_W)) u_snd_dec (
      .word_i(snd_word), .kind_o(snd_kind), .bcast_o(snd_bcast), .tag_o(snd_tag));

   doorbell_decode #(.WORD_W(WORD_W), .TYPE_LSB(TYPE_LSB), .TYPE_W(TYPE_W),
                     .BCAST_BIT(BCAST_BIT), .ID_W(ID_W)) u_clr_dec (
      .word_i(clr_word), .kind_o(clr_kind), .bcast_o(unused_clr_bcast),
      .tag_o(unused_clr_tag));

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
      doorbell_slot #(.ID_W(ID_W), .ID_RST(i)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .snd_valid  (snd_valid),
         .snd_kind   (snd_kind),
         .snd_bcast  (snd_bcast),
         .snd_tag    (snd_tag),
         .clr_sel    (clr_valid && clr_core == IDX_W'(i)),
         .clr_kind   (clr_kind),
         .id_sel     (id_we && id_core == IDX_W'(i)),
         .id_val     (id_val),
         .pend_norm_o(pend_norm[i]),
         .pend_crit_o(pend_crit[i]),
         .irq_o      (irq_pulse[i])
      );
   end

   // R3
   guest_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && snd_kind == DB_NONE) |=> (irq_pulse == '0));
   // R4
   bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && snd_bcast && snd_kind != DB_NONE) |=> (&irq_pulse));
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!snd_valid && !clr_valid) |=> ($stable(pend_norm) && $stable(pend_crit)));
endmodule

// File: tb/sim_doorbell_router.sv
`timescale 1ns/1ps
module sim_doorbell_router;
   localparam int N = 4;
   localparam int XW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          snd_valid = 1'b0;
   logic [31:0]   snd_word = '0;
   logic          clr_valid = 1'b0;
   logic [XW-1:0] clr_core = '0;
   logic [31:0]   clr_word = '0;
   logic          id_we = 1'b0;
   logic [XW-1:0] id_core = '0;
   logic [13:0]   id_val = '0;
   logic [N-1:0]  pend_norm, pend_crit, irq_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [N-1:0] e_norm = '0, e_crit = '0, e_irq = '0;
   logic [13:0]  ids [N];

   always #2.5 clk = ~clk;

   doorbell_router #(.NUM_CORES(N)) u0 (
      .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_word(snd_word),
      .clr_valid(clr_valid), .clr_core(clr_core), .clr_word(clr_word),
      .id_we(id_we), .id_core(id_core), .id_val(id_val),
      .pend_norm(pend_norm), .pend_crit(pend_crit), .irq_pulse(irq_pulse));

   function automatic logic [31:0] mk(int t, bit b, logic [13:0] tag);
      return {5'(t), b, 12'b0, tag};
   endfunction

   task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic chk_all(string req);
      chk(req, "pend_norm", pend_norm, e_norm);
      chk(req, "pend_crit", pend_crit, e_crit);
      chk(req, "irq_pulse", irq_pulse, e_irq);
   endtask

   // One command cycle, then model update and checks; then verify pulse ended.
   task automatic step(string req, bit sv, logic [31:0] sw, bit cv,
                       int cc, logic [31:0] cw);
      logic [N-1:0] hit;
      int t, ct;
      @(negedge clk);
      snd_valid = sv; snd_word = sw;
      clr_valid = cv; clr_core = XW'(cc); clr_word = cw;
      @(negedge clk);
      snd_valid = 1'b0; clr_valid = 1'b0;
      t = int'(sw[31:27]);
      ct = int'(cw[31:27]);
      hit = '0;
      if (sv && t <= 1)
         for (int c = 0; c < N; c++)
            if (sw[26] || sw[13:0] == ids[c]) hit[c] = 1'b1;
      if (cv && ct == 0) e_norm[cc] = 1'b0;
      if (cv && ct == 1) e_crit[cc] = 1'b0;
      if (t == 0) e_norm = e_norm | hit;
      if (t == 1) e_crit = e_crit | hit;
      e_irq = hit;
      chk_all(req);
      @(negedge clk);
      e_irq = '0;
      chk(req, "irq_pulse after", irq_pulse, e_irq);
   endtask

   task automatic t_reset;
      chk_all("R1");
      // R1: core 2 answers to reset ID 2
      step("R1", 1'b1, mk(0, 1'b0, 14'd2), 1'b0, 0, '0);
   endtask

   task automatic t_types;
      step("R2", 1'b1, mk(0, 1'b0, 14'd1), 1'b0, 0, '0);
      step("R2", 1'b1, mk(1, 1'b0, 14'd3), 1'b0, 0, '0);
      // R3 guest and undefined types, broadcast, no effect
      step("R3", 1'b1, mk(2, 1'b1, 14'd0), 1'b0, 0, '0);
      step("R3", 1'b1, mk(3, 1'b1, 14'd0), 1'b0, 0, '0);
      step("R3", 1'b1, mk(4, 1'b1, 14'd0), 1'b0, 0, '0);
      step("R3", 1'b1, mk(9, 1'b1, 14'd0), 1'b0, 0, '0);
   endtask

   task automatic t_target;
      step("R4", 1'b1, mk(0, 1'b0, 14'h3fff), 1'b0, 0, '0);
      step("R4", 1'b1, mk(1, 1'b1, 14'h3fff), 1'b0, 0, '0);
      step("R5", 1'b1, mk(0, 1'b0, 14'd0), 1'b0, 0, '0);
   endtask

   task automatic t_clear;
      step("R6", 1'b0, '0, 1'b1, 1, mk(0, 1'b1, 14'd0));
      step("R6", 1'b0, '0, 1'b1, 0, mk(1, 1'b0, 14'd2));
      step("R6", 1'b0, '0, 1'b1, 3, mk(3, 1'b0, 14'd3));
      step("R6", 1'b0, '0, 1'b1, 2, mk(7, 1'b0, 14'd2));
   endtask

   task automatic t_simul;
      step("R6", 1'b0, '0, 1'b1, 2, mk(0, 1'b0, 14'd0));
      step("R7", 1'b1, mk(0, 1'b0, 14'd2), 1'b1, 2, mk(0, 1'b0, 14'd0));
   endtask

   task automatic t_idwrite;
      @(negedge clk);
      id_we = 1'b1; id_core = 2'd1; id_val = 14'h1234;
      @(negedge clk);
      id_we = 1'b0;
      ids[1] = 14'h1234;
      step("R6", 1'b0, '0, 1'b1, 1, mk(1, 1'b0, 14'd0));
      step("R8", 1'b1, mk(1, 1'b0, 14'h1234), 1'b0, 0, '0);
      step("R8", 1'b1, mk(0, 1'b0, 14'd1), 1'b0, 0, '0);
   endtask

   task automatic t_hold;
      repeat (5) @(negedge clk);
      chk_all("R9");
   endtask

   initial begin
      for (int c = 0; c < N; c++) ids[c] = 14'(c);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_types();
      t_target();
      t_clear();
      t_simul();
      t_idwrite();
      t_hold();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule